// File: doc/BRIEF.md
# Sprite Segment Inverse-Transform Tester

This block decides, for an 80-pixel stretch of one scanline, which sprite covers each pixel and where that pixel lands inside the sprite. It works on 16 pixels at a time, and it makes five passes over the stretch for every sprite. For each sprite it fetches the translation and a 3-bit matrix selector through an arbitrated read port. It picks one of eight 2x2 inverse transforms from a table input. It then maps every screen pixel back into the sprite's own space. A pixel whose mapped coordinates both fall inside the sprite square is marked as hit, and the block reports its coordinates shifted to be non-negative. Sprites are visited from index 0 upward, and the first sprite that covers a pixel claims it.

The block avoids a multiplier per lane. The products with the scanline Y and the product for the first pixel of the stretch are formed once per sprite. Every further pixel adds the matrix's X coefficient to its left neighbour. Several instances can share one sprite store behind a fixed-priority arbiter, because the read request is held until it is granted.

The controller is a five-state machine:

| State | Role | Transitions |
|---|---|---|
| ST_IDLE | Waits for a start. | Goes to ST_FETCH on start. Goes to ST_DONE on start with a zero count. |
| ST_FETCH | Requests sprite `idx`. | Goes to ST_SETUP on grant. |
| ST_SETUP | Forms the shared products. | Always goes to ST_PASS. |
| ST_PASS | Evaluates 16 lanes per cycle. | After the fifth pass, goes to ST_FETCH for the next sprite, or to ST_DONE after the last sprite. |
| ST_DONE | Raises the done strobe. | Always goes back to ST_IDLE. |

Top module: `sprite_seg_tester`

## Requirements
- R1: While reset is held and after it is released, `seg_done`, `spr_req` and every bit of `seg_hit` are 0.
- R2: A start is accepted only in the idle state. On acceptance the block latches the segment X, the line Y and the sprite count, and clears all 80 hit flags. A count above 16 is treated as 16. A start that arrives while the block is busy is ignored.
- R3: To fetch a sprite, `spr_req` is raised with `spr_addr` set to the sprite index. Both stay unchanged until the cycle in which `spr_gnt` is high. The sprite data is taken only in that cycle. Sprites are fetched in the order 0, 1, …, count-1.
- R4: `mat_tbl` holds 8 entries of 64 bits, and entry e occupies bits [64e+63:64e]. Inside an entry, bits 15:0 hold the X coefficient for u and bits 31:16 hold the Y coefficient for u. Bits 47:32 hold the X coefficient for v and bits 63:48 hold the Y coefficient for v. Each coefficient is a signed value with 11 fraction bits. A sprite uses the entry named by its 3-bit `spr_mat`.
- R5: All coordinates use a signed fixed-point format with 11 fraction bits. For pixel j (0..79), let dx = (seg_x+j)·2048 − tx and dy = line_y·2048 − ty. Then u = floor(dx·a/2048) + floor(dy·b/2048), and v is formed the same way with c and d.
- R6: A pixel hits a sprite exactly when −8192 ≤ u < 8192 and −8192 ≤ v < 8192, which is the range −4.0 to 4.0 with the upper end excluded.
- R7: For a hit pixel, the 14-bit lane fields carry u+8192 and v+8192, each in the range 0 to 16383. The 4-bit id field carries the sprite index.
- R8: Once a pixel holds a hit, no later sprite in the same segment changes its flag, coordinates or id. The lowest-indexed covering sprite therefore wins.
- R9: `seg_done` is high for exactly one cycle after the last pass of the last sprite. The results stay unchanged until the next accepted start.
- R10: When the grant arrives in the first request cycle, `seg_done` is high after clock edge 1+7·N, where edge 1 is the edge that samples the start and N is the effective sprite count. A zero count gives done after edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seg_start | input | 1 | Begin a segment (accepted when idle) |
| seg_x | input | 12 | Integer X of the first pixel of the segment |
| line_y | input | 12 | Integer scanline Y |
| spr_count | input | 5 | Number of sprites to test |
| spr_req | output | 1 | Sprite read request |
| spr_addr | output | 4 | Sprite index being requested |
| spr_gnt | input | 1 | Arbiter grant; the data below is valid in this cycle |
| spr_tx | input | 24 | Sprite X translation, signed, 11 fraction bits |
| spr_ty | input | 24 | Sprite Y translation, signed, 11 fraction bits |
| spr_mat | input | 3 | Matrix table entry selector |
| mat_tbl | input | 512 | Eight inverse 2x2 matrices |
| seg_done | output | 1 | One-cycle segment complete strobe |
| seg_hit | output | 80 | Per-pixel hit flags |
| seg_u | output | 1120 | Per-pixel offset u, 14 bits per pixel |
| seg_v | output | 1120 | Per-pixel offset v, 14 bits per pixel |
| seg_id | output | 320 | Per-pixel winning sprite index, 4 bits per pixel |

## Verification
A wrong running X accumulator or lane step shows up as a one-pixel shift or as a stretched hit run. That error appears in the segment results at the next `seg_done`, at most 1+7·N cycles after the start. A counter fault in the pass or sprite index shows up as missing or repeated fetch addresses on the request port, in the cycle it happens. It also shows up as a wrong done latency. A fault in the priority logic shows up at `seg_done` as a wrong id or coordinates on pixels covered by overlapping sprites. Random transforms and grant delays are mixed with exact edge placements at −4.0 and 4.0.

// File: rtl/sst_pkg.sv
package sst_pkg;
    localparam int SST_FRAC  = 11;
    localparam int SST_CW    = 24;
    localparam int SST_MW    = 16;
    localparam int SST_PXW   = 12;
    localparam int SST_MAT_N = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PASS,
        ST_DONE
    } sst_state_e;
endpackage

// File: rtl/sst_setup.sv
// Per-sprite shared products: Y terms once per line, X term for lane 0 only.
module sst_setup #(
    parameter int PXW  = sst_pkg::SST_PXW,
    parameter int CW   = sst_pkg::SST_CW,
    parameter int MW   = sst_pkg::SST_MW,
    parameter int FRAC = sst_pkg::SST_FRAC,
    parameter int AW   = CW + MW - FRAC + 3
) (
    input  logic [PXW-1:0]       seg_x,
    input  logic [PXW-1:0]       line_y,
    input  logic signed [CW-1:0] tx,
    input  logic signed [CW-1:0] ty,
    input  logic signed [MW-1:0] ma,
    input  logic signed [MW-1:0] mb,
    input  logic signed [MW-1:0] mc,
    input  logic signed [MW-1:0] md,
    output logic signed [AW-1:0] base_u,
    output logic signed [AW-1:0] base_v
);
    localparam int PW  = CW + 1 + MW;
    localparam int PAD = CW + 1 - PXW - FRAC;

    logic signed [CW:0]   px_fp, py_fp, tx_e, ty_e, dx0, dy;
    logic signed [PW-1:0] p_xa, p_yb, p_xc, p_yd;
    logic signed [AW-1:0] s_xa, s_yb, s_xc, s_yd;

    assign px_fp = {{PAD{1'b0}}, seg_x, {FRAC{1'b0}}};
    assign py_fp = {{PAD{1'b0}}, line_y, {FRAC{1'b0}}};
    assign tx_e  = {tx[CW-1], tx};
    assign ty_e  = {ty[CW-1], ty};
    assign dx0   = px_fp - tx_e;
    assign dy    = py_fp - ty_e;

    // the Y products are common to every pixel of the line
    assign p_yb = PW'(dy) * PW'(mb);
    assign p_yd = PW'(dy) * PW'(md);
    // X products formed for the first pixel of the segment only
    assign p_xa = PW'(dx0) * PW'(ma);
    assign p_xc = PW'(dx0) * PW'(mc);

    assign s_xa = AW'(p_xa >>> FRAC);
    assign s_yb = AW'(p_yb >>> FRAC);
    assign s_xc = AW'(p_xc >>> FRAC);
    assign s_yd = AW'(p_yd >>> FRAC);

    assign base_u = s_xa + s_yb;
    assign base_v = s_xc + s_yd;
endmodule

// File: rtl/sst_lane_array.sv
// 16-lane step chain: lane k = lane k-1 + X coefficient, then range test.
module sst_lane_array #(
    parameter int LANES = 16,
    parameter int MW    = sst_pkg::SST_MW,
    parameter int FRAC  = sst_pkg::SST_FRAC,
    parameter int AW    = 32,
    parameter int LW    = FRAC + 3
) (
    input  logic [AW-1:0]         run_u,
    input  logic [AW-1:0]         run_v,
    input  logic signed [MW-1:0]  step_u,
    input  logic signed [MW-1:0]  step_v,
    output logic [LANES-1:0]      lane_hit,
    output logic [LANES*LW-1:0]   lane_lu,
    output logic [LANES*LW-1:0]   lane_lv,
    output logic [AW-1:0]         nxt_u,
    output logic [AW-1:0]         nxt_v
);
    localparam logic [AW-1:0] HALF = AW'(1) << (FRAC + 2);

    logic [AW-1:0] su, sv;
    logic [AW-1:0] cu [LANES];
    logic [AW-1:0] cv [LANES];
    logic [AW-1:0] ou [LANES];
    logic [AW-1:0] ov [LANES];

    assign su = {{(AW-MW){step_u[MW-1]}}, step_u};
    assign sv = {{(AW-MW){step_v[MW-1]}}, step_v};

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            if (k == 0) begin : g_head
                assign cu[k] = run_u;
                assign cv[k] = run_v;
            end else begin : g_link
                assign cu[k] = cu[k-1] + su;
                assign cv[k] = cv[k-1] + sv;
            end
            // shift [-4.0,4.0) onto [0,8.0): inside iff the high bits are clear
            assign ou[k] = cu[k] + HALF;
            assign ov[k] = cv[k] + HALF;
            assign lane_hit[k] = (ou[k][AW-1:LW] == '0) && (ov[k][AW-1:LW] == '0);
            assign lane_lu[k*LW +: LW] = ou[k][LW-1:0];
            assign lane_lv[k*LW +: LW] = ov[k][LW-1:0];
        end
    endgenerate

    assign nxt_u = cu[LANES-1] + su;
    assign nxt_v = cv[LANES-1] + sv;
endmodule

// File: rtl/sst_seg_store.sv
// Segment result store with first-hit-wins priority.
module sst_seg_store #(
    parameter int LANES  = 16,
    parameter int PASSES = 5,
    parameter int LW     = 14,
    parameter int IW     = 4,
    parameter int PSW    = 3,
    parameter int SEG    = LANES * PASSES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [PSW-1:0]       wr_pass,
    input  logic [IW-1:0]        wr_id,
    input  logic [LANES-1:0]     lane_hit,
    input  logic [LANES*LW-1:0]  lane_lu,
    input  logic [LANES*LW-1:0]  lane_lv,
    output logic [SEG-1:0]       seg_hit,
    output logic [SEG*LW-1:0]    seg_u,
    output logic [SEG*LW-1:0]    seg_v,
    output logic [SEG*IW-1:0]    seg_id
);
    logic [SEG-1:0] hit_q;
    logic [LW-1:0]  u_q  [SEG];
    logic [LW-1:0]  v_q  [SEG];
    logic [IW-1:0]  id_q [SEG];

    genvar j;
    generate
        for (j = 0; j < SEG; j++) begin : g_pix
            localparam int LN = j % LANES;
            localparam int PJ = j / LANES;
            logic we;
            assign we = wr_en && (wr_pass == PSW'(PJ)) && lane_hit[LN] && !hit_q[j];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hit_q[j] <= 1'b0;
                    u_q[j]   <= '0;
                    v_q[j]   <= '0;
                    id_q[j]  <= '0;
                end else if (clr) begin
                    hit_q[j] <= 1'b0;
                    u_q[j]   <= '0;
                    v_q[j]   <= '0;
                    id_q[j]  <= '0;
                end else if (we) begin
                    hit_q[j] <= 1'b1;
                    u_q[j]   <= lane_lu[LN*LW +: LW];
                    v_q[j]   <= lane_lv[LN*LW +: LW];
                    id_q[j]  <= wr_id;
                end
            end

            assign seg_hit[j]          = hit_q[j];
            assign seg_u[j*LW +: LW]   = u_q[j];
            assign seg_v[j*LW +: LW]   = v_q[j];
            assign seg_id[j*IW +: IW]  = id_q[j];

            // R8
            hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hit_q[j] && !clr) |=> (hit_q[j] && $stable(u_q[j]) &&
                                        $stable(v_q[j]) && $stable(id_q[j])));
        end
    endgenerate
endmodule

// File: rtl/sprite_seg_tester.sv
module sprite_seg_tester
    import sst_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int PASSES = 5,
    parameter int NSPR   = 16,
    parameter int PXW    = SST_PXW,
    parameter int CW     = SST_CW,
    parameter int MW     = SST_MW,
    parameter int FRAC   = SST_FRAC,
    parameter int MAT_N  = SST_MAT_N,
    localparam int SEG   = LANES * PASSES,
    localparam int IW    = (NSPR > 1) ? $clog2(NSPR) : 1,
    localparam int MIW   = (MAT_N > 1) ? $clog2(MAT_N) : 1,
    localparam int LW    = FRAC + 3,
    localparam int ENT_W = 4 * MW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    seg_start,
    input  logic [PXW-1:0]          seg_x,
    input  logic [PXW-1:0]          line_y,
    input  logic [IW:0]             spr_count,
    output logic                    spr_req,
    output logic [IW-1:0]           spr_addr,
    input  logic                    spr_gnt,
    input  logic signed [CW-1:0]    spr_tx,
    input  logic signed [CW-1:0]    spr_ty,
    input  logic [MIW-1:0]          spr_mat,
    input  logic [MAT_N*ENT_W-1:0]  mat_tbl,
    output logic                    seg_done,
    output logic [SEG-1:0]          seg_hit,
    output logic [SEG*LW-1:0]       seg_u,
    output logic [SEG*LW-1:0]       seg_v,
    output logic [SEG*IW-1:0]       seg_id
);
    localparam int PSW = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam int AW  = CW + MW - FRAC + 3;

    sst_state_e state_q, state_d;

    logic [PXW-1:0]       segx_q, liney_q;
    logic [IW:0]          cnt_q, cnt_in;
    logic [IW-1:0]        idx_q;
    logic [PSW-1:0]       pass_q;
    logic signed [CW-1:0] tx_q, ty_q;
    logic [MIW-1:0]       mat_q;
    logic [AW-1:0]        run_u_q, run_v_q;
    logic signed [MW-1:0] step_u_q, step_v_q;

    logic [ENT_W-1:0]     ent;
    logic signed [MW-1:0] m_a, m_b, m_c, m_d;
    logic signed [AW-1:0] base_u, base_v;
    logic [AW-1:0]        nxt_u, nxt_v;
    logic [LANES-1:0]     lane_hit;
    logic [LANES*LW-1:0]  lane_lu, lane_lv;
    logic                 last_pass, last_spr, accept, clr, wr_en;

    assign cnt_in    = (spr_count > (IW+1)'(NSPR)) ? (IW+1)'(NSPR) : spr_count;
    assign last_pass = (pass_q == PSW'(PASSES - 1));
    assign last_spr  = (({1'b0, idx_q} + (IW+1)'(1)) == cnt_q);
    assign accept    = (state_q == ST_IDLE) && seg_start;
    assign clr       = accept;
    assign wr_en     = (state_q == ST_PASS);

    // matrix entry lookup by the sprite's selector
    always_comb begin
        ent = mat_tbl[int'(mat_q)*ENT_W +: ENT_W];
        m_a = ent[0*MW +: MW];
        m_b = ent[1*MW +: MW];
        m_c = ent[2*MW +: MW];
        m_d = ent[3*MW +: MW];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (seg_start) state_d = (cnt_in == '0) ? ST_DONE : ST_FETCH;
            ST_FETCH: if (spr_gnt)   state_d = ST_SETUP;
            ST_SETUP: state_d = ST_PASS;
            ST_PASS:  if (last_pass) state_d = last_spr ? ST_DONE : ST_FETCH;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            segx_q   <= '0;
            liney_q  <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            pass_q   <= '0;
            tx_q     <= '0;
            ty_q     <= '0;
            mat_q    <= '0;
            run_u_q  <= '0;
            run_v_q  <= '0;
            step_u_q <= '0;
            step_v_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (seg_start) begin
                        segx_q  <= seg_x;
                        liney_q <= line_y;
                        cnt_q   <= cnt_in;
                        idx_q   <= '0;
                    end
                end
                ST_FETCH: begin
                    if (spr_gnt) begin
                        tx_q  <= spr_tx;
                        ty_q  <= spr_ty;
                        mat_q <= spr_mat;
                    end
                end
                ST_SETUP: begin
                    run_u_q  <= base_u;
                    run_v_q  <= base_v;
                    step_u_q <= m_a;
                    step_v_q <= m_c;
                    pass_q   <= '0;
                end
                ST_PASS: begin
                    run_u_q <= nxt_u;
                    run_v_q <= nxt_v;
                    pass_q  <= pass_q + PSW'(1);
                    if (last_pass && !last_spr) idx_q <= idx_q + IW'(1);
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        spr_req  = (state_q == ST_FETCH);
        spr_addr = idx_q;
        seg_done = (state_q == ST_DONE);
    end

    sst_setup #(.PXW(PXW), .CW(CW), .MW(MW), .FRAC(FRAC), .AW(AW)) setup_i (
        .seg_x  (segx_q),
        .line_y (liney_q),
        .tx     (tx_q),
        .ty     (ty_q),
        .ma     (m_a),
        .mb     (m_b),
        .mc     (m_c),
        .md     (m_d),
        .base_u (base_u),
        .base_v (base_v)
    );

    sst_lane_array #(.LANES(LANES), .MW(MW), .FRAC(FRAC), .AW(AW), .LW(LW)) lanes_i (
        .run_u    (run_u_q),
        .run_v    (run_v_q),
        .step_u   (step_u_q),
        .step_v   (step_v_q),
        .lane_hit (lane_hit),
        .lane_lu  (lane_lu),
        .lane_lv  (lane_lv),
        .nxt_u    (nxt_u),
        .nxt_v    (nxt_v)
    );

    sst_seg_store #(.LANES(LANES), .PASSES(PASSES), .LW(LW), .IW(IW), .PSW(PSW)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_en    (wr_en),
        .wr_pass  (pass_q),
        .wr_id    (idx_q),
        .lane_hit (lane_hit),
        .lane_lu  (lane_lu),
        .lane_lv  (lane_lv),
        .seg_hit  (seg_hit),
        .seg_u    (seg_u),
        .seg_v    (seg_v),
        .seg_id   (seg_id)
    );

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_req && !spr_gnt) |=> (spr_req && $stable(spr_addr)));

    // R3
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spr_req |-> ({1'b0, spr_addr} < cnt_q));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |=> !seg_done);

    // R10
    pass_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS) |-> ({1'b0, pass_q} < (PSW+1)'(PASSES)));
endmodule

// File: tb/sprite_seg_tester_tb.sv
module sprite_seg_tester_tb_top;
    localparam int SEG = 80;
    localparam int LW  = 14;
    localparam int IW  = 4;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               seg_start;
    logic [11:0]        seg_x, line_y;
    logic [4:0]         spr_count;
    logic               spr_req;
    logic [3:0]         spr_addr;
    logic               spr_gnt;
    logic signed [23:0] spr_tx, spr_ty;
    logic [2:0]         spr_mat;
    logic [511:0]       mat_tbl;
    logic               seg_done;
    logic [SEG-1:0]     seg_hit;
    logic [SEG*LW-1:0]  seg_u, seg_v;
    logic [SEG*IW-1:0]  seg_id;

    always #5 clk = ~clk;

    sprite_seg_tester dut_i (
        .clk(clk), .rst_n(rst_n), .seg_start(seg_start), .seg_x(seg_x), .line_y(line_y),
        .spr_count(spr_count), .spr_req(spr_req), .spr_addr(spr_addr), .spr_gnt(spr_gnt),
        .spr_tx(spr_tx), .spr_ty(spr_ty), .spr_mat(spr_mat), .mat_tbl(mat_tbl),
        .seg_done(seg_done), .seg_hit(seg_hit), .seg_u(seg_u), .seg_v(seg_v), .seg_id(seg_id)
    );

    int n_chk = 0, n_err = 0;
    int m_tx[16], m_ty[16], m_mat[16];
    int ma[8], mb[8], mc[8], md[8];
    int e_hit[SEG], e_u[SEG], e_v[SEG], e_id[SEG];
    bit fast_gnt = 1'b1;
    int exp_next = 0;
    bit prev_wait = 1'b0;
    logic [3:0] prev_addr = '0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_mat();
        for (int e = 0; e < 8; e++) begin
            mat_tbl[e*64 +: 16]      = 16'(ma[e]);
            mat_tbl[e*64 + 16 +: 16] = 16'(mb[e]);
            mat_tbl[e*64 + 32 +: 16] = 16'(mc[e]);
            mat_tbl[e*64 + 48 +: 16] = 16'(md[e]);
        end
    endtask

    // sprite store behind the arbiter: data is valid only in grant cycles (R3)
    always @(negedge clk) begin
        logic g;
        if (!rst_n) begin
            spr_gnt   = 1'b0;
            prev_wait = 1'b0;
        end else begin
            g = spr_req && (fast_gnt || ($urandom % 3 == 0));
            if (prev_wait)
                chk(spr_req && spr_addr == prev_addr, "R3", "request held until grant",
                    {spr_req, spr_addr}, {1'b1, prev_addr});
            prev_wait = spr_req && !g;
            prev_addr = spr_addr;
            if (g) begin
                chk(int'(spr_addr) == exp_next, "R3", "fetch order", spr_addr, exp_next);
                exp_next++;
                spr_tx  = 24'(m_tx[spr_addr]);
                spr_ty  = 24'(m_ty[spr_addr]);
                spr_mat = 3'(m_mat[spr_addr]);
            end else begin
                spr_tx  = 24'($urandom);
                spr_ty  = 24'($urandom);
                spr_mat = 3'($urandom);
            end
            spr_gnt = g;
        end
    end

    // reference model built from R5, R6, R7, R8
    task automatic model(int sx, int ly, int n);
        for (int j = 0; j < SEG; j++) begin
            e_hit[j] = 0; e_u[j] = 0; e_v[j] = 0; e_id[j] = 0;
            for (int s = 0; s < n; s++) begin
                longint dx, dy, u, v;
                int m;
                m  = m_mat[s];
                dx = longint'(sx + j) * 2048 - m_tx[s];
                dy = longint'(ly) * 2048 - m_ty[s];
                u  = ((dx * ma[m]) >>> 11) + ((dy * mb[m]) >>> 11);
                v  = ((dx * mc[m]) >>> 11) + ((dy * md[m]) >>> 11);
                if (u >= -8192 && u < 8192 && v >= -8192 && v < 8192) begin
                    e_hit[j] = 1; e_u[j] = int'(u) + 8192; e_v[j] = int'(v) + 8192; e_id[j] = s;
                    break;
                end
            end
        end
    endtask

    task automatic compare_all();
        for (int j = 0; j < SEG; j++) begin
            chk(seg_hit[j] == e_hit[j][0], "R6", $sformatf("lane %0d hit", j), seg_hit[j], e_hit[j]);
            if (e_hit[j] != 0) begin
                chk(int'(seg_u[j*LW +: LW]) == e_u[j], "R5", $sformatf("lane %0d u", j),
                    seg_u[j*LW +: LW], e_u[j]);
                chk(int'(seg_v[j*LW +: LW]) == e_v[j], "R7", $sformatf("lane %0d v", j),
                    seg_v[j*LW +: LW], e_v[j]);
                chk(int'(seg_id[j*IW +: IW]) == e_id[j], "R8", $sformatf("lane %0d id", j),
                    seg_id[j*IW +: IW], e_id[j]);
            end
        end
    endtask

    task automatic run_seg(int sx, int ly, int n, int exp_cyc, int inj);
        int cyc;
        int neff;
        neff = (n > 16) ? 16 : n;
        @(negedge clk);
        seg_x = 12'(sx); line_y = 12'(ly); spr_count = 5'(n); seg_start = 1'b1;
        exp_next = 0;
        cyc = 0;
        do begin
            @(posedge clk); #1;
            seg_start = 1'b0;
            cyc++;
            if (inj > 0 && cyc == inj) begin
                seg_start = 1'b1; seg_x = 12'(sx + 7); line_y = 12'(ly + 3); spr_count = 5'd1;
            end
        end while (!seg_done && cyc < 20000);
        chk(seg_done, "R9", "done strobe seen", seg_done, 1);
        if (exp_cyc >= 0) chk(cyc == exp_cyc, "R10", "done latency", cyc, exp_cyc);
        model(sx, ly, neff);
        compare_all();
        @(posedge clk); #1;
        chk(!seg_done, "R9", "done lasts one cycle", seg_done, 0);
    endtask

    task automatic rand_set(int sx, int ly);
        for (int e = 0; e < 8; e++) begin
            ma[e] = (($urandom % 2) ? 1 : -1) * (512 + int'($urandom % 3584));
            md[e] = (($urandom % 2) ? 1 : -1) * (512 + int'($urandom % 3584));
            mb[e] = int'($urandom % 2049) - 1024;
            mc[e] = int'($urandom % 2049) - 1024;
        end
        load_mat();
        for (int s = 0; s < 16; s++) begin
            m_tx[s]  = (sx + int'($urandom % 96) - 8) * 2048 + int'($urandom % 2048) - 1024;
            m_ty[s]  = (ly + int'($urandom % 9) - 4) * 2048 + int'($urandom % 2048) - 1024;
            m_mat[s] = int'($urandom % 8);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R9 watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        rst_n = 1'b0; seg_start = 1'b0; seg_x = '0; line_y = '0; spr_count = '0;
        spr_tx = '0; spr_ty = '0; spr_mat = '0; spr_gnt = 1'b0; mat_tbl = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!seg_done && !spr_req && seg_hit == '0, "R1", "outputs in reset",
            {seg_done, spr_req, 32'($countones(seg_hit))}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!seg_done && !spr_req && seg_hit == '0, "R1", "outputs after reset",
            {seg_done, spr_req, 32'($countones(seg_hit))}, 0);

        // directed tables: entry 5 identity, entry 1 half scale, others steep
        for (int e = 0; e < 8; e++) begin ma[e] = 20000; md[e] = 20000; mb[e] = 0; mc[e] = 0; end
        ma[5] = 2048; md[5] = 2048;
        ma[1] = 1024; md[1] = 1024;
        load_mat();

        // R4, R6: identity placed on integer pixel, exact -4.0 and 4.0 edges
        m_tx[0] = 120 * 2048; m_ty[0] = 50 * 2048; m_mat[0] = 5;
        run_seg(100, 50, 1, 8, 0);
        chk(seg_hit[16] && seg_u[16*LW +: LW] == 0, "R6", "u=-4.0 hits at offset 0",
            seg_u[16*LW +: LW], 0);
        chk(!seg_hit[24], "R6", "u=4.0 misses", seg_hit[24], 0);
        chk(seg_hit[17], "R4", "entry 5 selected", seg_hit[17], 1);
        chk(int'(seg_v[20*LW +: LW]) == 8192, "R7", "v offset at centre", seg_v[20*LW +: LW], 8192);

        // R2: count 0 clears previous hits; R10 zero-count latency
        run_seg(100, 50, 0, 1, 0);
        chk(seg_hit == '0, "R2", "flags cleared by start", $countones(seg_hit), 0);

        // R8: overlapping sprites, lower index wins
        m_tx[0] = 340 * 2048; m_ty[0] = 9 * 2048; m_mat[0] = 5;
        m_tx[1] = 340 * 2048; m_ty[1] = 9 * 2048; m_mat[1] = 1;
        run_seg(300, 9, 2, 15, 0);
        chk(int'(seg_id[40*IW +: IW]) == 0, "R8", "overlap owned by sprite 0", seg_id[40*IW +: IW], 0);
        chk(int'(seg_id[33*IW +: IW]) == 1, "R8", "outer ring owned by sprite 1", seg_id[33*IW +: IW], 1);

        // R9: results held after done
        repeat (10) @(negedge clk);
        compare_all();
        chk(!seg_done, "R9", "no further done while idle", seg_done, 0);

        // R2: count above 16 is clamped; R10 latency for 16 sprites
        rand_set(500, 200);
        run_seg(500, 200, 20, 1 + 7 * 16, 0);
        chk(exp_next == 16, "R2", "clamped sprite fetches", exp_next, 16);

        // R2: start while busy is ignored (random grant delays)
        fast_gnt = 1'b0;
        rand_set(800, 77);
        run_seg(800, 77, 4, -1, 3);
        chk(exp_next == 4, "R2", "busy start ignored", exp_next, 4);

        // random segments
        for (int t = 0; t < 25; t++) begin
            int sx, ly, n;
            sx = int'($urandom % 3000);
            ly = int'($urandom % 2000);
            n  = 1 + int'($urandom % 16);
            fast_gnt = (t % 2 == 0);
            rand_set(sx, ly);
            run_seg(sx, ly, n, fast_gnt ? 1 + 7 * n : -1, 0);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule